// File: doc/BRIEF.md
# Nearest integer divider calculator

This block works out the 8-bit setting for an integer clock divider so that the divided clock comes as close as it can to a requested frequency, given the frequency of the parent clock. A request is made by pulsing `start` with a 32-bit parent rate and a 32-bit requested rate. The block first forms the floor quotient of parent over requested. It then works out the rate each of the two neighbouring divider settings would give, and keeps whichever setting lands nearer the request. The result is held to the range 1..255, and one of two flags shows when the range limit was applied.

The same engine also runs the reverse operation. Given a parent rate and a stored 8-bit divider code, it returns the rate that code produces, and code 0 means the divided clock is stopped. All division is done by one shared restoring divider that produces one quotient bit per cycle. A computation therefore takes about a hundred cycles, and a readback about thirty-five. A one-cycle `done` pulse marks each result, and the result stays on the outputs until the next operation completes.

Top module: `nid_divsel`

## Requirements
- R1: `start` is accepted only while `busy` is low, and the inputs are sampled in that cycle; `busy` is high from the next cycle until `done`, and a `start` pulse while busy is ignored.
- R2: In compute mode (`op_read`=0) the candidate divider d is floor(P/R), and the rates P/(d+1) and P/d (integer quotients) are compared with R; the candidate whose rate is nearer R gives the result.
- R3: When both candidates are equally far from R, the larger divider d+1 is chosen.
- R4: A result above 255 (a floor quotient above 255, or rounding up from 255) gives `div_code`=255 with `clamp_hi`=1 and `clamp_lo`=0.
- R5: A floor quotient of 0 (R greater than P, or P equal to 0) gives `div_code`=1 with `clamp_lo`=1 and `clamp_hi`=0.
- R6: A requested rate of 0 is invalid: it gives `div_code`=255 and `clamp_hi`=1 without any division, and `done` follows one cycle after the start cycle.
- R7: In readback mode (`op_read`=1) `out_rate` becomes floor(P / `stored_code`), where the code is the 8-bit unsigned divider value.
- R8: In readback mode, a `stored_code` of 0 means the clock is off and gives `out_rate`=0.
- R9: `done` lasts exactly one cycle, and the outputs change only in that cycle. A compute leaves `out_rate` unchanged, and a readback leaves `div_code`, `clamp_hi` and `clamp_lo` unchanged.
- R10: After reset, `busy`, `done`, `div_code`, `clamp_hi`, `clamp_lo` and `out_rate` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_read | input | 1 | 0: compute a divider code, 1: read back the rate of a stored code |
| parent_rate | input | 32 | Parent clock rate P |
| req_rate | input | 32 | Requested rate R (compute mode) |
| stored_code | input | 8 | Stored divider code (readback mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_code | output | 8 | Chosen divider, 1..255 |
| clamp_hi | output | 1 | Result limited to 255 |
| clamp_lo | output | 1 | Result raised to 1 |
| out_rate | output | 32 | Readback rate |

## Verification
The checker tracks the operation kind and the zero cases from the cycle a `start` is accepted, so it relies on `start` being honoured only while `busy` is low. It also relies on the inputs being irrelevant after that cycle. The stimulus normally issues a new request only after the previous `done`, with one directed case that pulses `start` mid-operation to show that it is dropped. Expected codes in the table were worked out by hand from the floor and nearest-rate rules, including an exact tie and a round-up past 255.

// File: rtl/nid_pkg.sv
package nid_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_QUO,
      ST_LOW,
      ST_HIGH,
      ST_READ,
      ST_FIN
   } nid_state_e;

   localparam logic OP_PICK = 1'b0;
   localparam logic OP_READ = 1'b1;

endpackage

// File: rtl/nid_sdiv.sv
// Radix-2 restoring unsigned divider: one quotient bit per cycle.
module nid_sdiv #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic         rdy
);
   localparam int CNTW = $clog2(W) + 1;

   if (W < 2) begin : g_bad_width
      $error("nid_sdiv: W must be at least 2");
   end

   logic [W-1:0]    acc;
   logic [W-1:0]    quo_r;
   logic [W-1:0]    den_r;
   logic [CNTW-1:0] cnt;
   logic            run;

   logic [W:0]      shifted;
   logic [W-1:0]    diff;
   logic            take;

   always_comb begin
      shifted = {acc, quo_r[W-1]};
      take    = shifted >= {1'b0, den_r};
      diff    = shifted[W-1:0] - den_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         quo_r <= '0;
         den_r <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         rdy   <= 1'b0;
      end else begin
         rdy <= 1'b0;
         if (go) begin
            acc   <= '0;
            quo_r <= num;
            den_r <= den;
            cnt   <= CNTW'(W);
            run   <= 1'b1;
         end else if (run) begin
            acc   <= take ? diff : shifted[W-1:0];
            quo_r <= {quo_r[W-2:0], take};
            cnt   <= cnt - CNTW'(1);
            if (cnt == CNTW'(1)) begin
               run <= 1'b0;
               rdy <= 1'b1;
            end
         end
      end
   end

   assign quo = quo_r;

endmodule

// File: rtl/nid_pick.sv
// Chooses between floor divider q0 and q0+1 by comparing rate errors.
module nid_pick #(
   parameter int W  = 32,
   parameter int CW = 8
) (
   input  logic [W-1:0]  req,
   input  logic [W-1:0]  q0,
   input  logic [W-1:0]  rate_up,
   input  logic [W-1:0]  rate_dn,
   output logic [CW-1:0] code,
   output logic          sat
);
   localparam logic [W:0] LIMIT = {{(W+1-CW){1'b0}}, {CW{1'b1}}};

   logic [W-1:0] err_up;
   logic [W-1:0] err_dn;
   logic         bump;
   logic [W:0]   sum;

   always_comb begin
      err_up = (req >= rate_up) ? (req - rate_up) : (rate_up - req);
      err_dn = (req >= rate_dn) ? (req - rate_dn) : (rate_dn - req);
      bump   = err_up <= err_dn;
      sum    = {1'b0, q0} + {{W{1'b0}}, bump};
      sat    = sum > LIMIT;
      code   = sat ? LIMIT[CW-1:0] : sum[CW-1:0];
   end

endmodule

// File: rtl/nid_divsel.sv
module nid_divsel #(
   parameter int W  = 32,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_read,
   input  logic [W-1:0]  parent_rate,
   input  logic [W-1:0]  req_rate,
   input  logic [CW-1:0] stored_code,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] div_code,
   output logic          clamp_hi,
   output logic          clamp_lo,
   output logic [W-1:0]  out_rate
);
   import nid_pkg::*;

   localparam logic [W-1:0]  CODE_MAX_W = {{(W-CW){1'b0}}, {CW{1'b1}}};
   localparam logic [CW-1:0] CODE_MAX   = {CW{1'b1}};
   localparam logic [CW-1:0] CODE_ONE   = CW'(1);

   if (CW < 1 || CW >= W) begin : g_bad_cfg
      $error("nid_divsel: CW must lie in 1..W-1");
   end

   nid_state_e   st;
   logic [W-1:0]  p_q;
   logic [W-1:0]  r_q;
   logic [CW-1:0] c_q;
   logic [W-1:0]  q0_q;
   logic [W-1:0]  rup_q;
   logic          go_q;

   logic [W-1:0]  dv_den;
   logic [W-1:0]  dv_quo;
   logic          dv_rdy;
   logic [CW-1:0] pk_code;
   logic          pk_sat;

   always_comb begin
      case (st)
         ST_LOW:  dv_den = q0_q + W'(1);
         ST_HIGH: dv_den = q0_q;
         ST_READ: dv_den = {{(W-CW){1'b0}}, c_q};
         default: dv_den = r_q;
      endcase
   end

   nid_sdiv #(.W(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go_q),
      .num   (p_q),
      .den   (dv_den),
      .quo   (dv_quo),
      .rdy   (dv_rdy)
   );

   nid_pick #(.W(W), .CW(CW)) u_pick (
      .req     (r_q),
      .q0      (q0_q),
      .rate_up (rup_q),
      .rate_dn (dv_quo),
      .code    (pk_code),
      .sat     (pk_sat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         p_q      <= '0;
         r_q      <= '0;
         c_q      <= '0;
         q0_q     <= '0;
         rup_q    <= '0;
         go_q     <= 1'b0;
         div_code <= '0;
         clamp_hi <= 1'b0;
         clamp_lo <= 1'b0;
         out_rate <= '0;
      end else begin
         go_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  p_q <= parent_rate;
                  r_q <= req_rate;
                  c_q <= stored_code;
                  if (op_read == OP_READ) begin
                     if (stored_code == '0) begin
                        out_rate <= '0;
                        st       <= ST_FIN;
                     end else begin
                        st   <= ST_READ;
                        go_q <= 1'b1;
                     end
                  end else if (req_rate == '0) begin
                     div_code <= CODE_MAX;
                     clamp_hi <= 1'b1;
                     clamp_lo <= 1'b0;
                     st       <= ST_FIN;
                  end else begin
                     st   <= ST_QUO;
                     go_q <= 1'b1;
                  end
               end
            end
            ST_QUO: begin
               if (dv_rdy) begin
                  q0_q <= dv_quo;
                  if (dv_quo == '0) begin
                     div_code <= CODE_ONE;
                     clamp_hi <= 1'b0;
                     clamp_lo <= 1'b1;
                     st       <= ST_FIN;
                  end else if (dv_quo > CODE_MAX_W) begin
                     div_code <= CODE_MAX;
                     clamp_hi <= 1'b1;
                     clamp_lo <= 1'b0;
                     st       <= ST_FIN;
                  end else begin
                     st   <= ST_LOW;
                     go_q <= 1'b1;
                  end
               end
            end
            ST_LOW: begin
               if (dv_rdy) begin
                  rup_q <= dv_quo;
                  st    <= ST_HIGH;
                  go_q  <= 1'b1;
               end
            end
            ST_HIGH: begin
               if (dv_rdy) begin
                  div_code <= pk_code;
                  clamp_hi <= pk_sat;
                  clamp_lo <= 1'b0;
                  st       <= ST_FIN;
               end
            end
            ST_READ: begin
               if (dv_rdy) begin
                  out_rate <= dv_quo;
                  st       <= ST_FIN;
               end
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_FIN);

endmodule

// File: rtl/nid_divsel_chk.sv
module nid_divsel_chk #(
   parameter int W  = 32,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          op_read,
   input logic [W-1:0]  req_rate,
   input logic [CW-1:0] stored_code,
   input logic          busy,
   input logic          done,
   input logic [CW-1:0] div_code,
   input logic          clamp_hi,
   input logic          clamp_lo,
   input logic [W-1:0]  out_rate
);
   logic op_q;
   logic code_zero_q;
   logic req_zero_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q        <= 1'b0;
         code_zero_q <= 1'b0;
         req_zero_q  <= 1'b0;
      end else if (start && !busy) begin
         op_q        <= op_read;
         code_zero_q <= (stored_code == '0);
         req_zero_q  <= (req_rate == '0);
      end
   end

   assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_pick_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !op_q) |-> (div_code != '0));

   assert_hi_is_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_hi |-> (div_code == {CW{1'b1}}));

   assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(clamp_hi && clamp_lo));

   assert_lo_is_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_lo |-> (div_code == CW'(1)));

   assert_zero_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !op_q && req_zero_q) |-> clamp_hi);

   assert_off_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q && code_zero_q) |-> (out_rate == '0));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || ($stable(div_code) && $stable(clamp_hi) && $stable(clamp_lo))));

   assert_rate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || $stable(out_rate)));

endmodule

bind nid_divsel nid_divsel_chk #(.W(W), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .op_read     (op_read),
   .req_rate    (req_rate),
   .stored_code (stored_code),
   .busy        (busy),
   .done        (done),
   .div_code    (div_code),
   .clamp_hi    (clamp_hi),
   .clamp_lo    (clamp_lo),
   .out_rate    (out_rate)
);

// File: tb/nid_divsel_bench.sv
`timescale 1ns/100ps
module nid_divsel_bench;
   localparam int W  = 32;
   localparam int CW = 8;
   localparam int NV = 17;

   typedef struct packed {
      logic        rd;
      logic [31:0] p;
      logic [31:0] x;
      logic [7:0]  code;
      logic        hi;
      logic        lo;
      logic [31:0] rate;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'd800,        32'd200,        8'd4,   1'b0, 1'b0, 32'd0},
      '{1'b0, 32'd1000,       32'd300,        8'd3,   1'b0, 1'b0, 32'd0},
      '{1'b0, 32'd1000,       32'd260,        8'd4,   1'b0, 1'b0, 32'd0},
      '{1'b0, 32'd120,        32'd50,         8'd3,   1'b0, 1'b0, 32'd0},
      '{1'b0, 32'd1000,       32'd3,          8'd255, 1'b1, 1'b0, 32'd0},
      '{1'b0, 32'd1000,       32'd4,          8'd250, 1'b0, 1'b0, 32'd0},
      '{1'b0, 32'd255900,     32'd1000,       8'd255, 1'b1, 1'b0, 32'd0},
      '{1'b0, 32'd50,         32'd100,        8'd1,   1'b0, 1'b1, 32'd0},
      '{1'b0, 32'd0,          32'd5,          8'd1,   1'b0, 1'b1, 32'd0},
      '{1'b0, 32'd1000,       32'd0,          8'd255, 1'b1, 1'b0, 32'd0},
      '{1'b0, 32'hFFFFFFFF,   32'h7FFFFFFF,   8'd2,   1'b0, 1'b0, 32'd0},
      '{1'b0, 32'd600000000,  32'd25000000,   8'd24,  1'b0, 1'b0, 32'd0},
      '{1'b1, 32'd800000000,  32'd4,          8'd0,   1'b0, 1'b0, 32'd200000000},
      '{1'b1, 32'd1000,       32'd3,          8'd0,   1'b0, 1'b0, 32'd333},
      '{1'b1, 32'hFFFFFFFF,   32'd255,        8'd0,   1'b0, 1'b0, 32'd16843009},
      '{1'b1, 32'd1000,       32'd0,          8'd0,   1'b0, 1'b0, 32'd0},
      '{1'b1, 32'd12345,      32'd1,          8'd0,   1'b0, 1'b0, 32'd12345}
   };

   string tags [NV] = '{"R2", "R2", "R2", "R3", "R4", "R2", "R4", "R5", "R5",
                        "R6", "R2", "R2", "R7", "R7", "R7", "R8", "R7"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_read = 1'b0;
   logic [W-1:0]  parent_rate = '0;
   logic [W-1:0]  req_rate = '0;
   logic [CW-1:0] stored_code = '0;
   logic          busy;
   logic          done;
   logic [CW-1:0] div_code;
   logic          clamp_hi;
   logic          clamp_lo;
   logic [W-1:0]  out_rate;

   int errs   = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   nid_divsel #(.W(W), .CW(CW)) u_nid_divsel (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .op_read     (op_read),
      .parent_rate (parent_rate),
      .req_rate    (req_rate),
      .stored_code (stored_code),
      .busy        (busy),
      .done        (done),
      .div_code    (div_code),
      .clamp_hi    (clamp_hi),
      .clamp_lo    (clamp_lo),
      .out_rate    (out_rate)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic rd, input logic [31:0] p, input logic [31:0] x,
                         output int lat);
      @(negedge clk);
      start       = 1'b1;
      op_read     = rd;
      parent_rate = p;
      req_rate    = x;
      stored_code = x[7:0];
      @(negedge clk);
      start = 1'b0;
      lat   = 1;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      if (!done) check("R1 timeout", 32'd0, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0]  m_code;
      logic        m_hi;
      logic        m_lo;
      logic [31:0] m_rate;
      int          lat;

      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 busy", {31'd0, busy}, 32'd0);
      check("R10 done", {31'd0, done}, 32'd0);
      check("R10 code", {24'd0, div_code}, 32'd0);
      check("R10 flags", {30'd0, clamp_hi, clamp_lo}, 32'd0);
      check("R10 rate", out_rate, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      m_code = '0; m_hi = 1'b0; m_lo = 1'b0; m_rate = '0;
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i].rd, VEC[i].p, VEC[i].x, lat);
         if (VEC[i].rd) begin
            m_rate = VEC[i].rate;
            check(tags[i], out_rate, m_rate);
            check("R9 readback keeps code", {22'd0, div_code, clamp_hi, clamp_lo},
                  {22'd0, m_code, m_hi, m_lo});
         end else begin
            m_code = VEC[i].code; m_hi = VEC[i].hi; m_lo = VEC[i].lo;
            check(tags[i], {24'd0, div_code}, {24'd0, m_code});
            check(tags[i], {30'd0, clamp_hi, clamp_lo}, {30'd0, m_hi, m_lo});
            check("R9 compute keeps rate", out_rate, m_rate);
         end
         if (i == 9) check("R6 latency", lat, 32'd1);
         @(negedge clk);
         check("R9 done one cycle", {31'd0, done}, 32'd0);
      end

      // R1: start while busy is ignored
      @(negedge clk);
      start = 1'b1; op_read = 1'b0; parent_rate = 32'd1000; req_rate = 32'd260;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 busy", {31'd0, busy}, 32'd1);
      start = 1'b1; parent_rate = 32'd50; req_rate = 32'd100;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      check("R1 result from first start", {22'd0, div_code, clamp_hi, clamp_lo},
            {22'd0, 8'd4, 1'b0, 1'b0});
      repeat (5) @(negedge clk);
      check("R1 idle after", {31'd0, busy}, 32'd0);
      check("R9 code held", {24'd0, div_code}, 32'd4);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule